// File: doc/BRIEF.md
# Minimal Configurable Register Processor Core

This block is a small in-order processor core that is meant to be placed many times on one chip. The cores are connected to each other only through their port banks. Each core has a configurable number of interchangeable general-purpose registers. It also has a bank of input ports, which it can read but never write, and a bank of output ports, which it can write but never read back. Every data path in a connected group of cores shares one data width. The core fetches one instruction word per cycle from an external read-only program memory through an address/data pair. It keeps working data in a small private RAM with a synchronous read.

The opcode menu is fixed, and each instance implements a subset of it, chosen by a 16-bit enable parameter. The menu covers:
- register load, clear and copy;
- add, increment and decrement;
- an unconditional jump and two conditional jumps;
- moves between the port banks and the registers;
- loads from and stores to the local RAM.

A stall input from the surrounding objects freezes the core. When the program counter steps past the last program address, the core stops and raises a done flag.

Top module: `lean_core`

## Requirements
- R1: While reset is high and on the first cycle after it falls, the fetch address is 0, every output port reads 0 and done is low. Reset also clears all general-purpose registers.
- R2: An instruction word is, from MSB to LSB: a 4-bit opcode, register field A, register field B and an immediate field. Opcodes 1, 2 and 3 load the immediate into rA, clear rA, and copy rB into rA.
- R3: Opcode 4 sets rA to rA+rB, opcode 5 increments rA and opcode 6 decrements rA. All three wrap modulo 2^DW.
- R4: Opcode 7 always jumps to the immediate. Opcode 8 jumps when rA equals rB, and opcode 9 jumps when rA is zero. A jump that is not taken, and every other completed instruction, goes to the next address.
- R5: Opcode 10 loads rA from input port B, and reads 0 when B is at or above the number of inputs. Opcode 11 drives output port B with rA. An output index at or above the number of outputs changes no output.
- R6: Opcode 12 stores rA into the RAM. Opcode 13 loads rA from the RAM, which is addressed by the low address bits of the immediate. Opcode 13 holds the fetch address for one extra cycle.
- R7: While stall is high, the fetch address, the output ports, done and all internal state keep their values.
- R8: Opcode 0, the unused codes 14 and 15, and any opcode whose bit in the enable mask is 0 change no register, output or RAM, and advance to the next address.
- R9: When the next address would reach or pass the program depth, done rises instead. Once done is high it stays high, and the fetch address and outputs stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze request from external objects |
| imem_word | input | INSN_W | Instruction word at the fetch address |
| in_regs | input | NIN*DW | Input ports, port i at bits [i*DW +: DW] |
| imem_addr | output | PC_W | Program counter, used as the fetch address |
| out_regs | output | NOUT*DW | Output ports, port i at bits [i*DW +: DW] |
| done | output | 1 | Program has run past its last address |

## Verification
The bench builds two cores with 8-bit data, four registers, two inputs, three outputs, a 32-word program and an 8-word RAM. The register index is therefore 2 bits wide, so the output index 3 and the input indices 2 and 3 fall outside the banks. The 8-bit immediate reaches jump targets beyond the program end and RAM addresses that need truncation. One core enables every opcode. The other has increment and equal-jump masked off, so that masked opcodes fall through while both cores run the same programs under random stalls.

// File: rtl/lean_core_pkg.sv
package lean_core_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LDI  = 4'd1,
        OP_CLR  = 4'd2,
        OP_MOV  = 4'd3,
        OP_ADD  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_JMP  = 4'd7,
        OP_JEQ  = 4'd8,
        OP_JZR  = 4'd9,
        OP_PIN  = 4'd10,
        OP_POUT = 4'd11,
        OP_ST   = 4'd12,
        OP_LD   = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } opcode_e;

    typedef enum logic [2:0] {
        SRC_ZERO, SRC_IMM, SRC_RB, SRC_SUM, SRC_INC, SRC_DEC, SRC_PORT, SRC_MEM
    } src_e;

    typedef enum logic [1:0] {
        JC_NONE, JC_ALWAYS, JC_EQ, JC_ZERO
    } jcond_e;

    typedef struct packed {
        logic   gpr_we;
        src_e   src;
        logic   out_we;
        logic   mem_we;
        logic   mem_rd;
        jcond_e jc;
    } ctrl_t;

    function automatic int clog2c(int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int idx_w(int ngpr, int nin, int nout);
        return clog2c(max3(ngpr, nin, nout));
    endfunction

    function automatic int imm_w(int dw, int ram_depth, int rom_depth);
        return max3(dw, clog2c(ram_depth), clog2c(rom_depth));
    endfunction

    function automatic ctrl_t op_ctrl(opcode_e op);
        ctrl_t c;
        c = '0;
        case (op)
            OP_LDI:  begin c.gpr_we = 1'b1; c.src = SRC_IMM;  end
            OP_CLR:  begin c.gpr_we = 1'b1; c.src = SRC_ZERO; end
            OP_MOV:  begin c.gpr_we = 1'b1; c.src = SRC_RB;   end
            OP_ADD:  begin c.gpr_we = 1'b1; c.src = SRC_SUM;  end
            OP_INC:  begin c.gpr_we = 1'b1; c.src = SRC_INC;  end
            OP_DEC:  begin c.gpr_we = 1'b1; c.src = SRC_DEC;  end
            OP_JMP:  c.jc = JC_ALWAYS;
            OP_JEQ:  c.jc = JC_EQ;
            OP_JZR:  c.jc = JC_ZERO;
            OP_PIN:  begin c.gpr_we = 1'b1; c.src = SRC_PORT; end
            OP_POUT: c.out_we = 1'b1;
            OP_ST:   c.mem_we = 1'b1;
            OP_LD:   begin c.gpr_we = 1'b1; c.src = SRC_MEM; c.mem_rd = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lean_core_decode.sv
module lean_core_decode
    import lean_core_pkg::*;
#(
    parameter int          IX_W   = 2,
    parameter int          IMM_W  = 8,
    parameter logic [15:0] OP_EN  = 16'hFFFF,
    localparam int         INSN_W = OPC_W + 2 * IX_W + IMM_W
) (
    input  logic [INSN_W-1:0] insn,
    output ctrl_t             ctrl,
    output logic [IX_W-1:0]   ra,
    output logic [IX_W-1:0]   rb,
    output logic [IMM_W-1:0]  imm
);

    opcode_e op;

    assign op  = opcode_e'(insn[INSN_W-1 -: OPC_W]);
    assign ra  = insn[IMM_W + IX_W +: IX_W];
    assign rb  = insn[IMM_W +: IX_W];
    assign imm = insn[IMM_W-1:0];

    // a masked-off opcode decodes exactly like the empty operation
    always_comb begin
        ctrl = op_ctrl(op);
        if (!OP_EN[op]) ctrl = '0;
    end

endmodule

// File: rtl/lean_core_gpr.sv
module lean_core_gpr #(
    parameter int DW   = 8,
    parameter int NGPR = 4,
    parameter int IX_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IX_W-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [IX_W-1:0] raddr_a,
    input  logic [IX_W-1:0] raddr_b,
    output logic [DW-1:0]   rdata_a,
    output logic [DW-1:0]   rdata_b
);

    logic [DW-1:0] q [NGPR];

    for (genvar g = 0; g < NGPR; g++) begin : g_reg
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)                          r <= '0;
            else if (we && int'(waddr) == g)  r <= wdata;
        end
        assign q[g] = r;
    end

    // indices beyond the bank read as zero
    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < NGPR; i++) begin
            if (int'(raddr_a) == i) rdata_a = q[i];
            if (int'(raddr_b) == i) rdata_b = q[i];
        end
    end

endmodule

// File: rtl/lean_core_obank.sv
module lean_core_obank #(
    parameter int DW   = 8,
    parameter int NOUT = 2,
    parameter int IX_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IX_W-1:0]    idx,
    input  logic [DW-1:0]      wdata,
    output logic [NOUT*DW-1:0] q
);

    for (genvar g = 0; g < NOUT; g++) begin : g_port
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)                        r <= '0;
            else if (we && int'(idx) == g)  r <= wdata;
        end
        assign q[g*DW +: DW] = r;
    end

endmodule

// File: rtl/lean_core_dram.sv
module lean_core_dram #(
    parameter int  DW    = 8,
    parameter int  DEPTH = 16,
    localparam int AW    = lean_core_pkg::clog2c(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && int'(addr) < DEPTH) mem[addr] <= wdata;
        rdata <= (int'(addr) < DEPTH) ? mem[addr] : '0;
    end

endmodule

// File: rtl/lean_core.sv
module lean_core
    import lean_core_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          NGPR      = 4,
    parameter int          NIN       = 2,
    parameter int          NOUT      = 2,
    parameter int          ROM_DEPTH = 32,
    parameter int          RAM_DEPTH = 16,
    parameter logic [15:0] OP_EN     = 16'hFFFF,
    localparam int         IX_W      = idx_w(NGPR, NIN, NOUT),
    localparam int         IMM_W     = imm_w(DW, RAM_DEPTH, ROM_DEPTH),
    localparam int         PC_W      = clog2c(ROM_DEPTH),
    localparam int         INSN_W    = OPC_W + 2 * IX_W + IMM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic [INSN_W-1:0]  imem_word,
    input  logic [NIN*DW-1:0]  in_regs,
    output logic [PC_W-1:0]    imem_addr,
    output logic [NOUT*DW-1:0] out_regs,
    output logic               done
);

    localparam int RAM_AW = clog2c(RAM_DEPTH);
    localparam int NX_W   = IMM_W + 1;

    ctrl_t            ctl;
    logic [IX_W-1:0]  ra, rb;
    logic [IMM_W-1:0] imm;

    logic [PC_W-1:0]  pc_q;
    logic             halt_q;
    logic             m2r_wait_q;

    logic             run, m2r_issue, advance, gpr_we, jump_taken, over;
    logic [DW-1:0]    rd_a, rd_b, in_val, ram_q, result;
    logic [NX_W-1:0]  seq_nx, nx;

    lean_core_decode #(.IX_W(IX_W), .IMM_W(IMM_W), .OP_EN(OP_EN)) u_dec (
        .insn (imem_word),
        .ctrl (ctl),
        .ra   (ra),
        .rb   (rb),
        .imm  (imm)
    );

    // sequencing: a load spends one cycle issuing the RAM read
    assign run       = !stall && !halt_q;
    assign m2r_issue = run && ctl.mem_rd && !m2r_wait_q;
    assign advance   = run && !m2r_issue;
    assign gpr_we    = advance && ctl.gpr_we;

    lean_core_gpr #(.DW(DW), .NGPR(NGPR), .IX_W(IX_W)) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .we      (gpr_we),
        .waddr   (ra),
        .wdata   (result),
        .raddr_a (ra),
        .raddr_b (rb),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    lean_core_obank #(.DW(DW), .NOUT(NOUT), .IX_W(IX_W)) u_obank (
        .clk   (clk),
        .rst   (rst),
        .we    (advance && ctl.out_we),
        .idx   (rb),
        .wdata (rd_a),
        .q     (out_regs)
    );

    lean_core_dram #(.DW(DW), .DEPTH(RAM_DEPTH)) u_dram (
        .clk   (clk),
        .we    (advance && ctl.mem_we),
        .addr  (imm[RAM_AW-1:0]),
        .wdata (rd_a),
        .rdata (ram_q)
    );

    always_comb begin
        in_val = '0;
        for (int i = 0; i < NIN; i++) begin
            if (int'(rb) == i) in_val = in_regs[i*DW +: DW];
        end
    end

    always_comb begin
        case (ctl.src)
            SRC_IMM:  result = imm[DW-1:0];
            SRC_RB:   result = rd_b;
            SRC_SUM:  result = rd_a + rd_b;
            SRC_INC:  result = rd_a + 1'b1;
            SRC_DEC:  result = rd_a - 1'b1;
            SRC_PORT: result = in_val;
            SRC_MEM:  result = ram_q;
            default:  result = '0;
        endcase
    end

    always_comb begin
        case (ctl.jc)
            JC_ALWAYS: jump_taken = 1'b1;
            JC_EQ:     jump_taken = (rd_a == rd_b);
            JC_ZERO:   jump_taken = (rd_a == '0);
            default:   jump_taken = 1'b0;
        endcase
    end

    // next address carried one bit wider than the immediate so a step
    // past the last word or a far jump target is seen as overflow
    assign seq_nx = {{(NX_W - PC_W){1'b0}}, pc_q} + 1'b1;
    assign nx     = jump_taken ? {1'b0, imm} : seq_nx;
    assign over   = (int'(nx) >= ROM_DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= '0;
            halt_q     <= 1'b0;
            m2r_wait_q <= 1'b0;
        end else if (m2r_issue) begin
            m2r_wait_q <= 1'b1;
        end else if (advance) begin
            m2r_wait_q <= 1'b0;
            if (over) halt_q <= 1'b1;
            else      pc_q   <= nx[PC_W-1:0];
        end
    end

    assign imem_addr = pc_q;
    assign done      = halt_q;

endmodule

// File: rtl/lean_core_chk.sv
module lean_core_chk #(
    parameter int PW = 5,
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          stall,
    input logic [PW-1:0] imem_addr,
    input logic [OW-1:0] out_regs,
    input logic          done,
    input logic          m2r_issue,
    input logic          advance,
    input logic          jump_taken
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !done && out_regs == '0));

    a_r7_stall_freeze: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(imem_addr) && $stable(out_regs) && $stable(done)));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r9_done_frozen: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(imem_addr) && $stable(out_regs)));

    a_r6_load_extra_cycle: assert property (@(posedge clk) disable iff (rst)
        m2r_issue |=> $stable(imem_addr));

    a_r4_fall_through: assert property (@(posedge clk) disable iff (rst)
        (advance && !jump_taken) |=> (done || imem_addr == $past(imem_addr) + 1'b1));

endmodule

bind lean_core lean_core_chk #(.PW(PC_W), .OW(NOUT * DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .imem_addr  (imem_addr),
    .out_regs   (out_regs),
    .done       (done),
    .m2r_issue  (m2r_issue),
    .advance    (advance),
    .jump_taken (jump_taken)
);

// File: tb/lean_core_tb.sv
module lean_core_tb;

    localparam int DW = 8, NGPR = 4, NIN = 2, NOUT = 3, ROMD = 32, RAMD = 8;
    localparam logic [15:0] MASK_A = 16'hFFFF;
    localparam logic [15:0] MASK_B = 16'hFEDF;   // no inc (5), no equal-jump (8)
    localparam logic [7:0]  IN0 = 8'h3C, IN1 = 8'h11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall_force = 1'b0;
    logic stall_en = 1'b0;
    logic rnd_bit = 1'b0;
    logic stall;
    logic [15:0] rom [ROMD];
    logic [4:0]  addr_a, addr_b;
    logic [15:0] word_a, word_b;
    logic [NOUT*DW-1:0] out_a, out_b;
    logic done_a, done_b;
    logic [NIN*DW-1:0] in_regs;

    int nchk = 0, nfail = 0;

    int m_r   [2][NGPR];
    int m_o   [2][NOUT];
    int m_mem [2][RAMD];
    int m_pc [2], m_wait [2], m_done [2];

    always #2 clk = ~clk;

    assign stall   = stall_force | (stall_en & rnd_bit);
    assign in_regs = {IN1, IN0};
    assign word_a  = rom[addr_a];
    assign word_b  = rom[addr_b];

    lean_core #(.DW(DW), .NGPR(NGPR), .NIN(NIN), .NOUT(NOUT), .ROM_DEPTH(ROMD),
                .RAM_DEPTH(RAMD), .OP_EN(MASK_A)) u_dut (
        .clk(clk), .rst(rst), .stall(stall), .imem_word(word_a), .in_regs(in_regs),
        .imem_addr(addr_a), .out_regs(out_a), .done(done_a));

    lean_core #(.DW(DW), .NGPR(NGPR), .NIN(NIN), .NOUT(NOUT), .ROM_DEPTH(ROMD),
                .RAM_DEPTH(RAMD), .OP_EN(MASK_B)) u_sub (
        .clk(clk), .rst(rst), .stall(stall), .imem_word(word_b), .in_regs(in_regs),
        .imem_addr(addr_b), .out_regs(out_b), .done(done_b));

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(int op, int a, int b, int imm);
        return {op[3:0], a[1:0], b[1:0], imm[7:0]};
    endfunction

    // behavioural reference, one step per clock edge
    task automatic model_step(int k);
        logic [15:0] w;
        int op, a, b, im, nxt;
        logic [15:0] mask;
        if (rst) begin
            for (int i = 0; i < NGPR; i++) m_r[k][i] = 0;
            for (int i = 0; i < NOUT; i++) m_o[k][i] = 0;
            m_pc[k] = 0; m_wait[k] = 0; m_done[k] = 0;
            return;
        end
        if (stall || m_done[k] != 0) return;
        mask = (k == 0) ? MASK_A : MASK_B;
        w  = rom[m_pc[k]];
        op = int'(w[15:12]); a = int'(w[11:10]); b = int'(w[9:8]); im = int'(w[7:0]);
        if (!mask[op]) op = 0;
        nxt = m_pc[k] + 1;
        case (op)
            1:  m_r[k][a] = im;
            2:  m_r[k][a] = 0;
            3:  m_r[k][a] = m_r[k][b];
            4:  m_r[k][a] = (m_r[k][a] + m_r[k][b]) % 256;
            5:  m_r[k][a] = (m_r[k][a] + 1) % 256;
            6:  m_r[k][a] = (m_r[k][a] + 255) % 256;
            7:  nxt = im;
            8:  if (m_r[k][a] == m_r[k][b]) nxt = im;
            9:  if (m_r[k][a] == 0) nxt = im;
            10: m_r[k][a] = (b == 0) ? int'(IN0) : (b == 1) ? int'(IN1) : 0;
            11: if (b < NOUT) m_o[k][b] = m_r[k][a];
            12: m_mem[k][im % RAMD] = m_r[k][a];
            13: if (m_wait[k] == 0) begin
                    m_wait[k] = 1; nxt = m_pc[k];
                end else begin
                    m_r[k][a] = m_mem[k][im % RAMD]; m_wait[k] = 0;
                end
            default: ;
        endcase
        if (nxt >= ROMD) m_done[k] = 1;
        else             m_pc[k] = nxt;
    endtask

    initial begin
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < RAMD; i++) m_mem[k][i] = 0;
    end

    always @(posedge clk) begin
        model_step(0);
        model_step(1);
    end

    // per-clock comparison against the reference, away from the active edge
    always @(negedge clk) begin
        rnd_bit <= ($urandom % 4) == 0;
        chk("R4", "u_dut fetch address", int'(addr_a), m_pc[0]);
        chk("R4", "u_sub fetch address", int'(addr_b), m_pc[1]);
        chk("R9", "u_dut done", int'(done_a), m_done[0]);
        chk("R9", "u_sub done", int'(done_b), m_done[1]);
        for (int j = 0; j < NOUT; j++) begin
            chk("R3", "u_dut output port", int'(out_a[j*DW +: DW]), m_o[0][j]);
            chk("R3", "u_sub output port", int'(out_b[j*DW +: DW]), m_o[1][j]);
        end
    end

    task automatic load_prog1();
        for (int i = 0; i < ROMD; i++) rom[i] = '0;
        rom[0]  = enc(1, 0, 0, 5);      // r0 = 5
        rom[1]  = enc(1, 1, 0, 250);    // r1 = 250
        rom[2]  = enc(4, 1, 0, 0);      // r1 = 255
        rom[3]  = enc(5, 1, 0, 0);      // r1 wraps to 0
        rom[4]  = enc(6, 1, 0, 0);      // r1 wraps to 255
        rom[5]  = enc(3, 2, 1, 0);      // r2 = r1
        rom[6]  = enc(2, 1, 0, 0);      // r1 = 0
        rom[7]  = enc(10, 3, 0, 0);     // r3 = in0
        rom[8]  = enc(11, 3, 0, 0);     // o0 = r3
        rom[9]  = enc(11, 2, 1, 0);     // o1 = r2
        rom[10] = enc(11, 0, 2, 0);     // o2 = r0
        rom[11] = enc(11, 0, 3, 0);     // out of range port
        rom[12] = enc(10, 0, 2, 0);     // r0 = in2 (absent) = 0
        rom[13] = enc(11, 0, 2, 0);     // o2 = 0
        rom[14] = enc(12, 2, 0, 11);    // ram[3] = r2
        rom[15] = enc(13, 1, 0, 3);     // r1 = ram[3]
        rom[16] = enc(11, 1, 2, 0);     // o2 = r1
        rom[17] = enc(7, 0, 0, 40);     // jump past the end
    endtask

    task automatic load_prog2();
        for (int i = 0; i < ROMD; i++) rom[i] = '0;
        rom[0]  = enc(1, 0, 0, 4);
        rom[1]  = enc(2, 1, 0, 0);
        rom[2]  = enc(5, 1, 0, 0);
        rom[3]  = enc(6, 0, 0, 0);
        rom[4]  = enc(9, 0, 0, 6);
        rom[5]  = enc(7, 0, 0, 2);
        rom[6]  = enc(11, 1, 0, 0);     // o0 = r1
        rom[7]  = enc(1, 2, 0, 4);
        rom[8]  = enc(8, 1, 2, 10);
        rom[9]  = enc(1, 3, 0, 7);
        rom[10] = enc(11, 3, 1, 0);     // o1 = r3
        rom[11] = 16'hE000;             // unused code 14
        rom[12] = 16'hF000;             // unused code 15
    endtask

    task automatic run_to_done();
        stall_en = 1'b1;
        while (!(done_a && done_b)) @(negedge clk);
        stall_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int held;
        logic [NOUT*DW-1:0] o_hold;
        load_prog1();
        repeat (3) @(negedge clk);
        chk("R1", "reset fetch address", int'(addr_a), 0);
        chk("R1", "reset outputs", int'(out_a), 0);
        chk("R1", "reset done", int'(done_a), 0);
        rst = 1'b0;
        run_to_done();
        chk("R2", "load/copy chain o1", int'(out_a[15:8]), 255);
        chk("R3", "wrap chain o1", int'(out_a[15:8]), 255);
        chk("R5", "input to output o0", int'(out_a[7:0]), int'(IN0));
        chk("R6", "store then load o2", int'(out_a[23:16]), 255);
        chk("R8", "masked inc o1", int'(out_b[15:8]), 254);
        chk("R6", "masked core load o2", int'(out_b[23:16]), 254);
        chk("R9", "far jump raises done", int'(done_a), 1);
        held = int'(addr_a);
        o_hold = out_a;
        repeat (6) @(negedge clk);
        chk("R9", "address frozen after done", int'(addr_a), held);
        chk("R9", "outputs frozen after done", int'(out_a), int'(o_hold));

        rst = 1'b1;
        load_prog2();
        repeat (2) @(negedge clk);
        chk("R1", "outputs cleared by reset", int'(out_a), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        stall_force = 1'b1;
        @(negedge clk);
        held = int'(addr_a);
        o_hold = out_a;
        repeat (8) @(negedge clk);
        chk("R7", "address held under stall", int'(addr_a), held);
        chk("R7", "outputs held under stall", int'(out_a), int'(o_hold));
        stall_force = 1'b0;
        run_to_done();
        chk("R4", "loop count o0", int'(out_a[7:0]), 4);
        chk("R4", "taken equal-jump o1", int'(out_a[15:8]), 0);
        chk("R8", "masked inc loop o0", int'(out_b[7:0]), 0);
        chk("R8", "masked equal-jump o1", int'(out_b[15:8]), 7);
        chk("R9", "fall off end done", int'(done_a), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule